// File: doc/BRIEF.md
# Video Line CRC Inserter and Checker

This block sits in a 20-bit parallel video path that carries one word per clock. The word holds two 10-bit channels side by side: bits 9:0 form channel 0 and bits 19:10 form channel 1. The block watches the stream for timing reference sequences. For each channel it computes an 18-bit CRC over every video line.

In generate mode, the block writes each channel's CRC into the two word slots that follow the line-number words after the end-of-active-video sequence. All other words pass through untouched.

In checker mode, the block leaves the stream as it is. It compares the CRC words it receives against its own result. It raises a one-word error pulse, plus a held error flag that stays high until the next line's end-of-active-video sequence. When the enable input is low, the CRC logic is idle and the stream passes through unchanged.

Top module: `vid_line_crc`

## Requirements
- R1: Each channel's CRC uses the generator x^18 + x^5 + x^4 + 1. It processes each 10-bit word least significant bit first, as a shift-right register with feedback taken from bit 0.
- R2: A timing reference is four consecutive words whose two channels both read 3FF, 000, 000, then XYZ. Both channels of the XYZ word must be equal and have bit 9 set. XYZ bit 6 = 1 marks end of active video; bit 6 = 0 marks start of active video. A pattern that appears in only one channel is ordinary data.
- R3: The CRC register is cleared on the start-of-active-video XYZ word. It then accumulates every word from the next word up to and including the second line-number word (LN1). This span includes the end-of-active-video words.
- R4: In generate mode, the 3rd word after the end-of-active-video XYZ (CRC0) is replaced per channel by CRC bits 8:0. The 4th word (CRC1) is replaced by CRC bits 17:9. Each value sits in word bits 8:0, and word bit 9 is the inverse of word bit 8.
- R5: Data and control share a fixed latency of two clocks from `din` to `dout`. Every word other than CRC0 and CRC1 leaves unchanged.
- R6: A word that enters with `crc_en` low leaves unchanged. Its `crc_err` and `err_hold` are low. The CRC tracking restarts from idle.
- R7: In checker mode (`crc_en` and `chk_mode` high), no word is altered. `crc_err` is high with the CRC1 output word exactly when bits 8:0 of CRC0 or CRC1 differ from the computed value, in either channel. Bit 9 of the received words is not compared.
- R8: `err_hold` rises together with `crc_err`. It stays high until the next end-of-active-video XYZ word reaches `dout`, and is low in that word's cycle. It is also low for any word outside checker mode.
- R9: `crc_err` is never high in any output cycle other than a CRC1 word in checker mode.
- R10: While reset is asserted, `dout`, `crc_err` and `err_hold` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_en | input | 1 | Enables CRC generation or checking for the word entering |
| chk_mode | input | 1 | 1 = check received CRC words, 0 = generate and insert |
| din | input | 20 | Input word; channel 0 in bits 9:0, channel 1 in bits 19:10 |
| dout | output | 20 | Output word, two clocks after `din` |
| crc_err | output | 1 | One-word error pulse aligned with the CRC1 output word |
| err_hold | output | 1 | Held error flag, cleared at the next end-of-active-video XYZ |

## Verification
The in-RTL assertions check several things on every cycle. CRC coverage stops after LN1, and the CRC1 slot always follows CRC0. A disabled word leaves the block exactly two clocks later, unchanged. An error pulse only appears in checker mode, always comes with the held flag, and the held flag persists until the next end-of-active-video.

Only the bench's line scenarios can show the rest. These cover the actual CRC values written into the slots for short, long and disabled lines, and the rejection of a timing pattern that appears in one channel only. They also cover error detection when either slot or channel is corrupted, the insensitivity to a flipped bit 9, and the held flag spanning into the following line.

// File: rtl/vcrc_pkg.sv
package vcrc_pkg;
  localparam int LANE_W = 10;
  localparam int CRC_W  = 18;
  localparam int HALF_W = CRC_W / 2;
  localparam int H_BIT  = 6;
  localparam logic [CRC_W-1:0] POLY_REFL = 18'h23000;

  // advance one channel CRC by one 10-bit word, bit 0 first
  function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] c,
                                                   input logic [LANE_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < LANE_W; i++) begin
      fb = r[0] ^ w[i];
      r  = r >> 1;
      if (fb) r = r ^ POLY_REFL;
    end
    return r;
  endfunction

  // place a 9-bit CRC half into a 10-bit word with inverted top bit
  function automatic logic [LANE_W-1:0] slot_word(input logic [HALF_W-1:0] b);
    return {~b[HALF_W-1], b};
  endfunction
endpackage

// File: rtl/vcrc_trs_track.sv
module vcrc_trs_track
  import vcrc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [LANES*LANE_W-1:0] word,
  output logic                    sav_hit,
  output logic                    eav_hit,
  output logic                    cover_now,
  output logic                    slot0,
  output logic                    slot1
);
  localparam int POS_W = 3;

  logic [LANES-1:0] l_one, l_zero, l_same;
  logic all_one, all_zero, xyz_ok, trs;
  logic o1, o2, o3, z1, z2;
  logic [POS_W-1:0] pos;
  logic cov;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_cmp
    assign l_one[g]  = (word[g*LANE_W +: LANE_W] == {LANE_W{1'b1}});
    assign l_zero[g] = (word[g*LANE_W +: LANE_W] == {LANE_W{1'b0}});
    assign l_same[g] = (word[g*LANE_W +: LANE_W] == word[LANE_W-1:0]);
  end

  assign all_one  = &l_one;
  assign all_zero = &l_zero;
  assign xyz_ok   = (&l_same) && word[LANE_W-1];
  assign trs      = o3 && z2 && z1 && xyz_ok;
  assign sav_hit  = trs && !word[H_BIT];
  assign eav_hit  = trs && word[H_BIT];
  assign cover_now = cov;
  assign slot0    = (pos == POS_W'(3));
  assign slot1    = (pos == POS_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o1 <= 1'b0; o2 <= 1'b0; o3 <= 1'b0; z1 <= 1'b0; z2 <= 1'b0;
    end else begin
      o1 <= all_one;  o2 <= o1; o3 <= o2;
      z1 <= all_zero; z2 <= z1;
    end
  end

  // pos: place of the current word after the end-of-active XYZ (1 = LN0)
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pos <= '0;
      cov <= 1'b0;
    end else begin
      if (eav_hit)                  pos <= POS_W'(1);
      else if (pos == POS_W'(4))    pos <= '0;
      else if (pos != '0)           pos <= pos + POS_W'(1);
      if (sav_hit)                  cov <= 1'b1;
      else if (pos == POS_W'(2))    cov <= 1'b0;
    end
  end

  p_cov_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pos == POS_W'(2) && !sav_hit) |=> !cover_now);

  p_slot_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot1 |-> $past(slot0));
endmodule

// File: rtl/vcrc_lane.sv
module vcrc_lane
  import vcrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic [LANE_W-1:0] word,
  output logic [LANE_W-1:0] ins0,
  output logic [LANE_W-1:0] ins1,
  output logic              mis0,
  output logic              mis1
);
  logic [CRC_W-1:0] crc;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (acc) crc <= crc_advance(crc, word);
  end

  assign ins0 = slot_word(crc[HALF_W-1:0]);
  assign ins1 = slot_word(crc[CRC_W-1:HALF_W]);
  assign mis0 = (word[HALF_W-1:0] != crc[HALF_W-1:0]);
  assign mis1 = (word[HALF_W-1:0] != crc[CRC_W-1:HALF_W]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
endmodule

// File: rtl/vid_line_crc.sv
module vid_line_crc
  import vcrc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    crc_en,
  input  logic                    chk_mode,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    crc_err,
  output logic                    err_hold
);
  localparam int WW = LANES * LANE_W;

  logic [WW-1:0] d1, dnext, ins0_w, ins1_w;
  logic en_q, chk_q, gen_on, chk_on;
  logic sav_hit, eav_hit, cover_now, slot0, slot1;
  logic [LANES-1:0] mis0_v, mis1_v;
  logic bad0, err_now;
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= '0; en_q <= 1'b0; chk_q <= 1'b0; warm <= '0;
    end else begin
      d1 <= din; en_q <= crc_en; chk_q <= chk_mode;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign gen_on = en_q && !chk_q;
  assign chk_on = en_q && chk_q;

  vcrc_trs_track #(.LANES(LANES)) u_trk (
    .clk(clk), .rst_n(rst_n), .run(en_q), .word(d1),
    .sav_hit(sav_hit), .eav_hit(eav_hit), .cover_now(cover_now),
    .slot0(slot0), .slot1(slot1)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vcrc_lane u_lane (
      .clk(clk), .rst_n(rst_n), .clr(sav_hit), .acc(cover_now),
      .word(d1[g*LANE_W +: LANE_W]),
      .ins0(ins0_w[g*LANE_W +: LANE_W]), .ins1(ins1_w[g*LANE_W +: LANE_W]),
      .mis0(mis0_v[g]), .mis1(mis1_v[g])
    );
  end

  always_comb begin
    if (gen_on && slot0)      dnext = ins0_w;
    else if (gen_on && slot1) dnext = ins1_w;
    else                      dnext = d1;
  end

  assign err_now = chk_on && slot1 && (bad0 || (|mis1_v));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; crc_err <= 1'b0; err_hold <= 1'b0; bad0 <= 1'b0;
    end else begin
      dout    <= dnext;
      crc_err <= err_now;
      if (slot0) bad0 <= |mis0_v;
      if (!chk_on || eav_hit) err_hold <= 1'b0;
      else if (err_now)       err_hold <= 1'b1;
    end
  end

  p_pass_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !$past(crc_en, 2)) |-> (dout == $past(din, 2)));

  p_err_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && crc_err) |-> ($past(crc_en, 2) && $past(chk_mode, 2)));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> err_hold);

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hold && chk_on && !eav_hit) |=> err_hold);
endmodule

// File: tb/sim_vid_line_crc.sv
`timescale 1ns/1ps
module sim_vid_line_crc;
  logic clk = 1'b0;
  logic rst_n;
  logic crc_en, chk_mode;
  logic [19:0] din, dout;
  logic crc_err, err_hold;

  always #2.5 clk = ~clk;

  vid_line_crc u0 (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .chk_mode(chk_mode),
    .din(din), .dout(dout), .crc_err(crc_err), .err_hold(err_hold)
  );

  typedef struct {
    logic [19:0] data;
    logic        err;
    logic        hold;
    bit          on;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit cur_en = 0, cur_chk = 0;
  logic exp_hold = 1'b0;

  function automatic logic [17:0] rev18(input logic [17:0] v);
    logic [17:0] r;
    for (int i = 0; i < 18; i++) r[i] = v[17-i];
    return r;
  endfunction

  // normal-form left-shift CRC on a reversed register
  function automatic logic [17:0] ref_crc(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r;
    logic fb;
    r = rev18(c);
    for (int i = 0; i < 10; i++) begin
      fb = r[17] ^ w[i];
      r = {r[16:0], 1'b0};
      if (fb) r = r ^ 18'h00031;
    end
    return rev18(r);
  endfunction

  function automatic logic [9:0] fmt9(input logic [8:0] b);
    logic [9:0] o;
    o[8:0] = b;
    o[9] = !b[8];
    return o;
  endfunction

  function automatic logic [9:0] dat(input int seed, input int i, input int k);
    return 10'(4 + ((seed * 37 + i * 11 + k * 101) % 1016));
  endfunction

  task automatic put(input logic [19:0] w, input logic [19:0] ed, input logic ee,
                     input string tag, input bit on);
    exp_t it;
    @(negedge clk);
    din = w; crc_en = cur_en; chk_mode = cur_chk;
    if (!(cur_en && cur_chk)) exp_hold = 1'b0;
    it.data = ed; it.err = ee; it.hold = exp_hold; it.on = on; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: scoreboard pops two words behind the driver
  always @(posedge clk) begin
    #2;
    if (q.size() >= 2) begin
      exp_t it;
      it = q.pop_front();
      if (it.on) begin
        checks++;
        if (dout !== it.data) begin
          errors++;
          $display("FAIL %s: dout=%h expected %h", it.tag, dout, it.data);
        end
        checks++;
        if (crc_err !== it.err) begin
          errors++;
          $display("FAIL R7 R9: crc_err=%b expected %b", crc_err, it.err);
        end
        checks++;
        if (err_hold !== it.hold) begin
          errors++;
          $display("FAIL R8: err_hold=%b expected %b", err_hold, it.hold);
        end
      end
    end
  end

  // corrupt: 0 none, 1 CRC0 ch0 bit3, 2 CRC1 ch1 bit5, 3 CRC0 ch0 bit9
  task automatic send_line(input bit en, input bit chk, input int nact, input int seed,
                           input int corrupt, input bit fake);
    logic [17:0] c0, c1;
    logic [9:0] lo, hi, ln0;
    logic [19:0] w, in0, in1, e0, e1;
    logic eflag;
    string dtag, stag;
    logic [9:0] fk [4];
    fk[0] = 10'h3FF; fk[1] = 10'h000; fk[2] = 10'h000; fk[3] = 10'h274;
    cur_en = en; cur_chk = chk;
    dtag = !en ? "R6" : (fake ? "R2" : "R5");
    stag = !en ? "R6" : (chk ? "R7" : "R1 R3 R4");
    repeat (2) put({10'h200, 10'h040}, {10'h200, 10'h040}, 1'b0, dtag, 1);
    put(20'hFFFFF, 20'hFFFFF, 1'b0, dtag, 1);
    put(20'h00000, 20'h00000, 1'b0, dtag, 1);
    put(20'h00000, 20'h00000, 1'b0, dtag, 1);
    put({10'h200, 10'h200}, {10'h200, 10'h200}, 1'b0, dtag, 1);
    c0 = '0; c1 = '0;
    for (int i = 0; i < nact; i++) begin
      if (fake && i == 1) begin
        for (int k = 0; k < 4; k++) begin
          lo = fk[k]; hi = dat(seed, i, k + 2); w = {hi, lo};
          c0 = ref_crc(c0, lo); c1 = ref_crc(c1, hi);
          put(w, w, 1'b0, "R2", 1);
        end
      end
      lo = dat(seed, i, 0); hi = dat(seed, i, 1); w = {hi, lo};
      c0 = ref_crc(c0, lo); c1 = ref_crc(c1, hi);
      put(w, w, 1'b0, dtag, 1);
    end
    for (int k = 0; k < 4; k++) begin
      lo = fk[k]; w = {lo, lo};
      c0 = ref_crc(c0, lo); c1 = ref_crc(c1, lo);
      if (k == 3) exp_hold = 1'b0;
      put(w, w, 1'b0, (k == 3) ? "R8" : dtag, 1);
    end
    ln0 = 10'h200 | 10'((seed & 8'h7F) << 2);
    c0 = ref_crc(c0, ln0); c1 = ref_crc(c1, ln0);
    put({ln0, ln0}, {ln0, ln0}, 1'b0, dtag, 1);
    c0 = ref_crc(c0, 10'h200); c1 = ref_crc(c1, 10'h200);
    put({10'h200, 10'h200}, {10'h200, 10'h200}, 1'b0, dtag, 1);
    e0 = {fmt9(c1[8:0]), fmt9(c0[8:0])};
    e1 = {fmt9(c1[17:9]), fmt9(c0[17:9])};
    if (en && chk) begin
      in0 = e0; in1 = e1;
      if (corrupt == 1) in0 = in0 ^ 20'h00008;
      if (corrupt == 2) in1 = in1 ^ 20'h08000;
      if (corrupt == 3) in0 = in0 ^ 20'h00200;
    end else begin
      in0 = {10'h155, 10'h2AA}; in1 = {10'h2AA, 10'h155};
    end
    if (!(en && !chk)) begin e0 = in0; e1 = in1; end
    eflag = en && chk && (corrupt == 1 || corrupt == 2);
    put(in0, e0, 1'b0, stag, 1);
    if (eflag) exp_hold = 1'b1;
    put(in1, e1, eflag, stag, 1);
    repeat (3) put({10'h200, 10'h040}, {10'h200, 10'h040}, 1'b0, dtag, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5: watchdog expired, run incomplete, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = 20'hABCDE; crc_en = 1'b1; chk_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; if (dout !== 20'h0) begin errors++; $display("FAIL R10: dout=%h expected 00000", dout); end
    checks++; if (crc_err !== 1'b0) begin errors++; $display("FAIL R10: crc_err=%b expected 0", crc_err); end
    checks++; if (err_hold !== 1'b0) begin errors++; $display("FAIL R10: err_hold=%b expected 0", err_hold); end
    rst_n = 1'b1; crc_en = 1'b0;
    send_line(1, 0, 6, 3, 0, 0);   // R4 short generate line
    send_line(1, 0, 1, 9, 0, 0);   // R3 minimum active span
    send_line(1, 0, 5, 17, 0, 1);  // R2 one-channel pattern is data
    send_line(0, 0, 4, 21, 0, 0);  // R6 disabled, slots pass
    send_line(1, 1, 5, 30, 0, 0);  // R7 correct CRC, no error
    send_line(1, 1, 5, 41, 1, 0);  // R7 CRC0 ch0 corrupted
    send_line(1, 1, 3, 52, 0, 0);  // R8 hold spans into next line
    send_line(1, 1, 4, 63, 2, 0);  // R7 CRC1 ch1 corrupted
    send_line(0, 0, 2, 70, 0, 0);  // R6 disable clears hold
    send_line(1, 1, 4, 77, 3, 0);  // R7 bit 9 not compared
    send_line(1, 0, 40, 88, 0, 0); // R1 long generate line
    repeat (4) put({10'h200, 10'h040}, 20'h0, 1'b0, "R5", 0);
    summary();
    $finish;
  end
endmodule